// File: doc/BRIEF.md
# Transmit descriptor writeback engine

This block services a ring of transmit descriptors kept in a word-addressed memory. It reaches that memory through one request/grant port. The port carries a write enable and an error response. For each descriptor the engine reads the control word and checks the ownership bit. It then fetches the buffer length and the buffer address, and offers them to a downstream frame mover over a valid/ready handshake. The engine then waits for the mover's done pulse and samples a 64-bit transmit timestamp in the same cycle.

To close a descriptor, the engine first writes the timestamp into the extended words, if one was requested and the extended layout is enabled. It then rewrites word 0 with the ownership bit cleared, which hands the descriptor back to software. A configuration input picks a 4-word or an 8-word descriptor. A descriptor that software still holds suspends the engine until a poll pulse arrives. Any memory error response halts the engine until reset.

Descriptor layout: word 0 holds control and status, word 1 holds the length in bits [13:0], word 2 holds the buffer address, and words 6 and 7 hold the timestamp (low half, then high half).

Top module: `txdesc_engine`

## Requirements
- R1: After reset the engine issues no memory request, holds `frm_valid` low and shows all status outputs low. It stays idle until a `poll_demand` pulse, which starts the walk at `ring_base`.
- R2: Descriptor pitch is 4 words with `cfg_ext`=0 and 8 words with `cfg_ext`=1. After a close, the next descriptor is the current address plus the pitch. If word 0 bit 21 (ring end) was set, the next descriptor is `ring_base` instead.
- R3: Word 0 is read first. If its bit 31 (owner) is 0, the engine raises `stat_suspended` and makes no further access until `poll_demand`. It then re-reads that same word 0. If bit 31 is 1, words 1 and 2 are read next.
- R4: The handoff presents `frm_addr` = word 2 and `frm_len` = word 1 bits [13:0]. Both are held with `frm_valid` high until `frm_ready`.
- R5: A length of up to 8192 is handed off. A larger length skips the handoff, and the descriptor closes with word 0 status bit 0 set.
- R6: The word 0 writeback keeps bits [30:20] as read, writes bit 31 as 0, and replaces bits [19:0] with status. Status bit 17 is timestamp-written, bit 0 is length error, and all other status bits are 0.
- R7: When word 0 bit 25 was set, `cfg_ext`=1 and the frame was handed off, the engine writes the `frm_ts` value sampled with `frm_done`. Bits [31:0] go to word 6 and bits [63:32] go to word 7. Status bit 17 is set.
- R8: With `cfg_ext`=0, words 4 to 7 of a descriptor are never accessed and bit 17 is never set, even when bit 25 requests a timestamp.
- R9: The timestamp writes complete before the word 0 writeback of the same descriptor.
- R10: An error response on any granted access moves the engine to a halt. `stat_fatal` goes high and `stat_err` records the cause: bit 0 for a read, bit 1 for a write. A write that got an error is not counted as done. No request or handoff follows, `poll_demand` is ignored, and only reset clears the state.
- R11: A memory request holds its address, write enable and write data unchanged until `mem_gnt`. The access completes in the cycle in which `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ext | input | 1 | 1 selects 8-word descriptors, 0 selects 4-word |
| ring_base | input | AW | Word address of the first descriptor |
| poll_demand | input | 1 | Pulse that starts or resumes the walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_err | input | 1 | Error response, valid with the grant |
| frm_valid | output | 1 | Buffer offered to the frame mover |
| frm_ready | input | 1 | Frame mover accepts the buffer |
| frm_addr | output | 32 | Buffer address |
| frm_len | output | LEN_W | Buffer length in bytes |
| frm_done | input | 1 | Frame finished, timestamp valid |
| frm_ts | input | 64 | Transmit timestamp |
| stat_suspended | output | 1 | Halted on a descriptor owned by software |
| stat_fatal | output | 1 | Halted by a bus error |
| stat_err | output | 2 | Bus error cause: bit 0 read, bit 1 write |

## Verification
A read samples data, and a write is final, at the first rising edge where `mem_req` and `mem_gnt` are both high. The next request appears one cycle later. The bench decides each cycle's grant and error at the falling edge. It compares the pending access with the head of a queue that a behavioural ring walk builds from the memory image, so every access is checked in the one cycle it completes. A handoff completes at the edge with `frm_ready` high. The timestamp is taken at the edge with `frm_done`, and the first timestamp write is requested in the next cycle. Status outputs change one cycle after the access that causes them, so status checks wait for the flag and then sample mid-cycle.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    localparam int DW         = 32;
    localparam int OWN_POS    = 31;
    localparam int TSREQ_POS  = 25;
    localparam int EOR_POS    = 21;
    localparam int CTL_LSB    = 20;
    localparam int TSOK_POS   = 17;
    localparam int LENERR_POS = 0;
    localparam int CTL_W      = OWN_POS - CTL_LSB;
    localparam int TSREQ_IDX  = TSREQ_POS - CTL_LSB;
    localparam int EOR_IDX    = EOR_POS - CTL_LSB;
    localparam int SHORT_WORDS = 4;
    localparam int LONG_WORDS  = 8;
    localparam int LEN_OFF    = 1;
    localparam int BUF_OFF    = 2;
    localparam int TS_LO_OFF  = 6;
    localparam int TS_HI_OFF  = 7;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_RD0   = 4'd1,
        S_RD1   = 4'd2,
        S_RD2   = 4'd3,
        S_HAND  = 4'd4,
        S_WAIT  = 4'd5,
        S_WR6   = 4'd6,
        S_WR7   = 4'd7,
        S_WR0   = 4'd8,
        S_SUSP  = 4'd9,
        S_FATAL = 4'd10
    } tx_state_e;
endpackage

// File: rtl/txdesc_nextptr.sv
module txdesc_nextptr
    import txdesc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          ext,
    input  logic          eor,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP_SHORT = AW'(SHORT_WORDS);
    localparam logic [AW-1:0] STEP_LONG  = AW'(LONG_WORDS);

    always_comb begin
        if (eor) begin
            nxt = base;
        end else begin
            nxt = cur + (ext ? STEP_LONG : STEP_SHORT);
        end
    end
endmodule

// File: rtl/txdesc_close.sv
module txdesc_close
    import txdesc_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  logic             ts_ok,
    input  logic             len_err,
    output logic [DW-1:0]    word
);
    logic [CTL_LSB-1:0] status;

    always_comb begin
        status             = '0;
        status[TSOK_POS]   = ts_ok;
        status[LENERR_POS] = len_err;
        word               = {1'b0, ctl, status};
    end
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txdesc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int LEN_W   = 14,
    parameter int MAX_LEN = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ext,
    input  logic [AW-1:0]    ring_base,
    input  logic             poll_demand,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             frm_valid,
    input  logic             frm_ready,
    output logic [31:0]      frm_addr,
    output logic [LEN_W-1:0] frm_len,
    input  logic             frm_done,
    input  logic [63:0]      frm_ts,
    output logic             stat_suspended,
    output logic             stat_fatal,
    output logic [1:0]       stat_err
);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    typedef struct packed {
        tx_state_e        st;
        logic [AW-1:0]    cur;
        logic [CTL_W-1:0] ctl;
        logic [LEN_W-1:0] len;
        logic [31:0]      bufa;
        logic [63:0]      ts;
        logic             ts_ok;
        logic             len_err;
        logic [1:0]       err;
    } eng_t;

    eng_t          q, d;
    logic [2:0]    off;
    logic [AW-1:0] next_ptr;
    logic [31:0]   close_word;

    txdesc_nextptr #(.AW(AW)) u_nextptr (
        .cur  (q.cur),
        .base (ring_base),
        .ext  (cfg_ext),
        .eor  (q.ctl[EOR_IDX]),
        .nxt  (next_ptr)
    );

    txdesc_close u_close (
        .ctl     (q.ctl),
        .ts_ok   (q.ts_ok),
        .len_err (q.len_err),
        .word    (close_word)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        off       = 3'd0;
        mem_wdata = '0;
        frm_valid = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (poll_demand) begin
                    d.cur = ring_base;
                    d.st  = S_RD0;
                end
            end
            S_RD0: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    d.ctl = mem_rdata[OWN_POS-1:CTL_LSB];
                    d.st  = mem_rdata[OWN_POS] ? S_RD1 : S_SUSP;
                end
            end
            S_RD1: begin
                mem_req = 1'b1;
                off     = 3'(LEN_OFF);
                if (mem_gnt) begin
                    d.len     = mem_rdata[LEN_W-1:0];
                    d.len_err = mem_rdata[LEN_W-1:0] > LEN_CAP;
                    d.ts_ok   = 1'b0;
                    d.st      = S_RD2;
                end
            end
            S_RD2: begin
                mem_req = 1'b1;
                off     = 3'(BUF_OFF);
                if (mem_gnt) begin
                    d.bufa = mem_rdata;
                    d.st   = q.len_err ? S_WR0 : S_HAND;
                end
            end
            S_HAND: begin
                frm_valid = 1'b1;
                if (frm_ready) begin
                    d.st = S_WAIT;
                end
            end
            S_WAIT: begin
                if (frm_done) begin
                    d.ts = frm_ts;
                    if (q.ctl[TSREQ_IDX] && cfg_ext) begin
                        d.ts_ok = 1'b1;
                        d.st    = S_WR6;
                    end else begin
                        d.st = S_WR0;
                    end
                end
            end
            S_WR6: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                off       = 3'(TS_LO_OFF);
                mem_wdata = q.ts[31:0];
                if (mem_gnt) begin
                    d.st = S_WR7;
                end
            end
            S_WR7: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                off       = 3'(TS_HI_OFF);
                mem_wdata = q.ts[63:32];
                if (mem_gnt) begin
                    d.st = S_WR0;
                end
            end
            S_WR0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = close_word;
                if (mem_gnt) begin
                    d.cur = next_ptr;
                    d.st  = S_RD0;
                end
            end
            S_SUSP: begin
                if (poll_demand) begin
                    d.st = S_RD0;
                end
            end
            S_FATAL: begin
            end
            default: d.st = S_FATAL;
        endcase
        if (mem_req && mem_gnt && mem_err) begin
            d.st = S_FATAL;
            if (mem_we) begin
                d.err[1] = 1'b1;
            end else begin
                d.err[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr       = q.cur + {{(AW-3){1'b0}}, off};
    assign frm_addr       = q.bufa;
    assign frm_len        = q.len;
    assign stat_suspended = (q.st == S_SUSP);
    assign stat_fatal     = (q.st == S_FATAL);
    assign stat_err       = q.err;

    // R11: a pending request stays unchanged until granted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: the halt is permanent until reset
    p_fatal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_fatal |=> stat_fatal);

    // R10: nothing leaves the engine once halted
    p_fatal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_fatal |-> (!mem_req && !frm_valid));

    // R10: the halt only follows an error response on a granted access
    p_fatal_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_fatal) |-> $past(mem_req && mem_gnt && mem_err));

    // R4: the offered buffer is held until accepted
    p_hand_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len)));

    // R5: oversize lengths never reach the frame mover
    p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_len <= LEN_CAP));

    // R3: a suspended engine stays off the memory port and the handoff
    p_susp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_suspended |-> (!mem_req && !frm_valid));

    // R6: a write to the descriptor head always releases ownership
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_addr == q.cur)) |-> !mem_wdata[OWN_POS]);
endmodule

// File: tb/txdesc_engine_test.sv
module txdesc_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ext = 1'b0;
    logic [15:0] ring_base = '0;
    logic        poll_demand = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata;
    logic        mem_err = 1'b0;
    logic        frm_valid;
    logic        frm_ready = 1'b0;
    logic [31:0] frm_addr;
    logic [13:0] frm_len;
    logic        frm_done = 1'b0;
    logic [63:0] frm_ts = '0;
    logic        stat_suspended, stat_fatal;
    logic [1:0]  stat_err;

    always #5 clk = ~clk;

    txdesc_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .ring_base(ring_base),
        .poll_demand(poll_demand), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_addr(frm_addr), .frm_len(frm_len),
        .frm_done(frm_done), .frm_ts(frm_ts), .stat_suspended(stat_suspended),
        .stat_fatal(stat_fatal), .stat_err(stat_err)
    );

    typedef struct { bit we; int addr; logic [31:0] data; string tag; } acc_t;
    typedef struct { logic [31:0] a; int len; } hand_t;

    logic [31:0] mem [0:255];
    logic [31:0] mdl [0:255];
    acc_t  exq[$];
    hand_t hq[$];
    int n_tests = 0, n_fail = 0;
    int acc_n = 0, err_at = -1, gcnt = 0;
    int fr_n = 0, mfr = 0, mcur = 0;
    int pend_done = 0, vwait = 0;
    bit prev_wait = 0, prev_we = 0;
    logic [15:0] prev_addr = '0;

    assign mem_rdata = mem[mem_addr[7:0]];

    function automatic logic [63:0] ts_of(input int n);
        return {32'hC0DE0000 + 32'(n), 32'h5A000000 + 32'(n * 7)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: grant pattern, error injection, per-access comparison
    always @(negedge clk) begin
        gcnt++;
        mem_gnt = (gcnt % 3) != 1;
        mem_err = 1'b0;
        #1;
        if (prev_wait) begin
            chk(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R11", "held request",
                {mem_req, mem_we, mem_addr}, {1'b1, prev_we, prev_addr});
        end
        prev_wait = mem_req && !mem_gnt;
        prev_addr = mem_addr;
        prev_we   = mem_we;
        if (mem_req && mem_gnt) begin
            if (acc_n == err_at) mem_err = 1'b1;
            acc_n++;
            if (exq.size() == 0) begin
                chk(1'b0, "R3", "unexpected access", {mem_we, mem_addr, mem_wdata}, 64'h0);
            end else begin
                acc_t e;
                e = exq.pop_front();
                chk(mem_we == e.we && int'(mem_addr) == e.addr && (!e.we || mem_wdata == e.data),
                    e.tag, "access", {mem_we, mem_addr, mem_wdata}, {e.we, e.addr[15:0], e.data});
            end
            if (mem_we && !mem_err) mem[mem_addr[7:0]] = mem_wdata;
        end
    end

    // frame mover: accepts after two cycles, finishes three cycles later
    always @(negedge clk) begin
        frm_done  = 1'b0;
        frm_ready = 1'b0;
        if (pend_done > 0) begin
            pend_done--;
            if (pend_done == 0) begin
                frm_done = 1'b1;
                frm_ts   = ts_of(fr_n);
                fr_n++;
            end
        end
        #2;
        if (frm_valid) begin
            vwait++;
            if (vwait >= 2) begin
                vwait     = 0;
                frm_ready = 1'b1;
                pend_done = 3;
                if (hq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected handoff", {frm_addr, 18'h0, frm_len}, 64'h0);
                end else begin
                    hand_t h;
                    h = hq.pop_front();
                    chk(frm_addr == h.a && int'(frm_len) == h.len, "R4", "handoff",
                        {frm_addr, 18'h0, frm_len}, {h.a, 18'h0, 14'(h.len)});
                end
            end
        end
    end

    // behavioural ring walk producing the expected access and handoff order
    task automatic model_walk(input bit ext, input int base);
        logic [31:0] w0, wb;
        logic [19:0] st;
        logic [63:0] ts;
        int len;
        for (int guard = 0; guard < 32; guard++) begin
            w0 = mdl[mcur];
            exq.push_back('{1'b0, mcur, 32'h0, "R2"});
            if (!w0[31]) break;
            exq.push_back('{1'b0, mcur + 1, 32'h0, "R2"});
            exq.push_back('{1'b0, mcur + 2, 32'h0, "R2"});
            len = int'(mdl[mcur + 1][13:0]);
            st  = '0;
            if (len > 8192) begin
                st[0] = 1'b1;
            end else begin
                hq.push_back('{mdl[mcur + 2], len});
                ts = ts_of(mfr);
                mfr++;
                if (w0[25] && ext) begin
                    exq.push_back('{1'b1, mcur + 6, ts[31:0], "R7 R9"});
                    exq.push_back('{1'b1, mcur + 7, ts[63:32], "R7 R9"});
                    mdl[mcur + 6] = ts[31:0];
                    mdl[mcur + 7] = ts[63:32];
                    st[17] = 1'b1;
                end
            end
            wb = {1'b0, w0[30:20], st};
            exq.push_back('{1'b1, mcur, wb, "R6"});
            mdl[mcur] = wb;
            mcur = w0[21] ? base : mcur + (ext ? 8 : 4);
        end
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exq.delete();
        hq.delete();
        mfr = fr_n;
    endtask

    task automatic fill_sentinel();
        for (int i = 0; i < 256; i++) mem[i] = 32'h5000_0000 | 32'(i);
    endtask

    task automatic sync_model();
        for (int i = 0; i < 256; i++) mdl[i] = mem[i];
    endtask

    task automatic pulse_poll();
        @(negedge clk);
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
    endtask

    task automatic wait_stop(input string req);
        int n;
        n = 0;
        while (!stat_suspended && !stat_fatal && n < 3000) begin
            @(negedge clk);
            n++;
        end
        #3;
        if (n >= 3000) chk(1'b0, req, "stop timeout", 64'(n), 64'd3000);
    endtask

    task automatic image_check(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i]) bad++;
        chk(bad == 0, req, "memory image mismatches", 64'(bad), 64'd0);
    endtask

    task automatic run_ring(input bit ext, input int base, input string req);
        sync_model();
        mcur = base;
        cfg_ext = ext;
        ring_base = 16'(base);
        model_walk(ext, base);
        pulse_poll();
        wait_stop(req);
    endtask

    initial begin
        int a0;
        fill_sentinel();
        hard_reset();
        @(negedge clk); #3;
        chk(!mem_req && !frm_valid, "R1", "outputs after reset", {mem_req, frm_valid}, 2'b00);
        chk(!stat_suspended && !stat_fatal && stat_err == 2'b00, "R1", "status after reset",
            {stat_suspended, stat_fatal, stat_err}, 4'h0);
        a0 = acc_n;
        repeat (6) @(negedge clk);
        chk(acc_n == a0, "R1", "idle without poll", 64'(acc_n), 64'(a0));

        // ring A: 4-word pitch, timestamp request ignored, boundary and oversize lengths
        mem[16] = 32'h8200_ABCD; mem[17] = 32'd100;  mem[18] = 32'h1000_0000;
        mem[20] = 32'h8040_0000; mem[21] = 32'd8192; mem[22] = 32'h2000_0040;
        mem[24] = 32'h8220_0000; mem[25] = 32'd9000; mem[26] = 32'h3000_0000;
        run_ring(1'b0, 16, "R3");
        chk(stat_suspended, "R3", "suspended on released descriptor", {63'h0, stat_suspended}, 64'd1);
        chk(exq.size() == 0 && hq.size() == 0, "R2", "ring A trace consumed", 64'(exq.size()), 64'd0);
        image_check("R8");
        chk(mem[16][17] == 1'b0, "R8", "no timestamp flag with short pitch", {63'h0, mem[16][17]}, 64'd0);
        chk(mem[24][0] == 1'b1 && mem[20][0] == 1'b0, "R5", "length error flags",
            {62'h0, mem[24][0], mem[20][0]}, 64'd2);
        a0 = acc_n;
        repeat (8) @(negedge clk);
        chk(acc_n == a0, "R3", "no access while suspended", 64'(acc_n), 64'(a0));

        // re-arm the descriptor the engine stopped on and resume
        mem[16] = 32'h8000_0007; mem[17] = 32'd12; mem[18] = 32'h4000_0000;
        sync_model();
        model_walk(1'b0, 16);
        pulse_poll();
        @(negedge clk);
        wait_stop("R3");
        chk(stat_suspended && exq.size() == 0 && hq.size() == 0, "R3", "resume after poll",
            64'(exq.size()), 64'd0);
        image_check("R6");

        // ring B: 8-word pitch with timestamps
        hard_reset();
        fill_sentinel();
        mem[64] = 32'h8200_0000; mem[65] = 32'd64;   mem[66] = 32'h5000_1000;
        mem[72] = 32'h8200_0000; mem[73] = 32'd9000; mem[74] = 32'h5000_2000;
        mem[80] = 32'h8620_0000; mem[81] = 32'd1;    mem[82] = 32'h5000_3000;
        run_ring(1'b1, 64, "R7");
        chk(stat_suspended && exq.size() == 0 && hq.size() == 0, "R2", "ring B trace consumed",
            64'(exq.size()), 64'd0);
        image_check("R7");
        chk(mem[64][17] == 1'b1 && mem[64][31] == 1'b0, "R7", "timestamp flag and release",
            {62'h0, mem[64][17], mem[64][31]}, 64'd2);
        chk(mem[78] == 32'h5000_004E && mem[79] == 32'h5000_004F, "R7", "oversize descriptor keeps extended words",
            {mem[78], mem[79]}, {32'h5000_004E, 32'h5000_004F});

        // bus error on a read
        hard_reset();
        fill_sentinel();
        mem[128] = 32'h8000_0000; mem[129] = 32'd20; mem[130] = 32'h6000_0000;
        mem[132] = 32'h8000_0000; mem[133] = 32'd30; mem[134] = 32'h6000_0100;
        err_at = acc_n + 4;
        run_ring(1'b0, 128, "R10");
        chk(stat_fatal && stat_err == 2'b01, "R10", "read error status", {stat_fatal, stat_err}, 3'b101);
        a0 = acc_n;
        pulse_poll();
        repeat (10) @(negedge clk);
        #3;
        chk(acc_n == a0 && !frm_valid && stat_fatal, "R10", "poll ignored while halted",
            64'(acc_n - a0), 64'd0);

        // bus error on the first timestamp write
        hard_reset();
        chk(!stat_fatal && stat_err == 2'b00, "R1", "reset clears halt", {stat_fatal, stat_err}, 3'b000);
        fill_sentinel();
        mem[160] = 32'h8220_0000; mem[161] = 32'd10; mem[162] = 32'h7000_0000;
        err_at = acc_n + 3;
        run_ring(1'b1, 160, "R10");
        chk(stat_fatal && stat_err == 2'b10, "R10", "write error status", {stat_fatal, stat_err}, 3'b110);
        chk(mem[166] == 32'h5000_00A6 && mem[160][31] == 1'b1, "R10", "no close after error",
            {mem[166], mem[160]}, {32'h5000_00A6, 32'h8220_0000});
        err_at = -1;
        hard_reset();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule